// File: doc/BRIEF.md
# Single-Cycle Control and Next-PC Unit

This block is the whole control path of a single-cycle processor that runs a small integer subset: three-register arithmetic and logic (add, sub, and, or, set-less-than), word load, word store, branch-if-equal and an absolute jump. The block takes in the instruction word, the zero flag from the ALU and the current program counter. In the same cycle it returns every datapath steering signal, the 3-bit operation code for the ALU, and the address to load into the PC register at the next edge.

The opcode and function decoders are merged into one unit, and the zero flag is one of its inputs. Because of this, the block gives out a resolved ALU operation and a resolved taken-branch signal, and no intermediate class code. The next-PC logic selects from three addresses: the sequential address, the branch target and the jump target. The jump target is built from the top PC bits and the 26-bit index. Encodings the block does not recognise are turned into a harmless no-op.

The register file, the ALU, the memories and the PC register sit outside this block and are connected around it.

Top module: `scu_ctrl`

## Requirements
- R1: For op 6'b000000 with func 6'b100000/100010/100100/100101/101010, alu_op is 3'b010/110/000/001/111 in that order. reg_dst=1 and reg_write=1. alu_src, mem_to_reg, mem_read, mem_write, jump and branch_taken are all 0.
- R2: For op 6'b100011 (load): alu_src=1, mem_read=1, mem_to_reg=1, reg_write=1, alu_op=3'b010. reg_dst, mem_write, jump and branch_taken are 0.
- R3: For op 6'b101011 (store): alu_src=1, mem_write=1, alu_op=3'b010. reg_dst, mem_to_reg, reg_write, mem_read, jump and branch_taken are 0.
- R4: For op 6'b000100 (branch-if-equal): alu_op=3'b110 and all datapath enables are 0. branch_taken equals alu_zero.
- R5: When branch_taken=1, pc_next = pc + 4 + (sign-extended instr[15:0] shifted left by 2), modulo 2^32. When a branch-if-equal sees alu_zero=0, pc_next = pc + 4.
- R6: For op 6'b000010 (jump): jump=1, branch_taken=0, all datapath enables are 0, alu_op=3'b010. pc_next = {pc[31:28], instr[25:0], 2'b00}, and this choice takes priority over every other next-PC source.
- R7: For every instruction that neither jumps nor takes a branch, pc_next = pc + 4 modulo 2^32, so 32'hFFFFFFFC wraps to 0.
- R8: Any other op, and op 6'b000000 with any other func, drives every control output (reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write, branch_taken, jump) to 0, alu_op to 3'b010 and pc_next to pc + 4.
- R9: alu_zero has no effect on any output except for a branch-if-equal instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| alu_zero | input | 1 | ALU result-is-zero flag |
| pc | input | 32 | Current program counter |
| reg_dst | output | 1 | Write register comes from the rd field (1) or the rt field (0) |
| alu_src | output | 1 | Second ALU operand is the sign-extended immediate |
| mem_to_reg | output | 1 | Register write data comes from data memory |
| reg_write | output | 1 | Register file write enable |
| mem_read | output | 1 | Data memory read enable |
| mem_write | output | 1 | Data memory write enable |
| branch_taken | output | 1 | Branch-if-equal resolved as taken |
| jump | output | 1 | Absolute jump decoded |
| alu_op | output | 3 | ALU operation code |
| pc_next | output | 32 | Address for the PC register at the next edge |

## Verification
The block has no state, so a decoding fault shows up at the ports in the same cycle that the instruction is applied. A wrong table entry shows as a wrong enable or a wrong alu_op. A wrong priority or a wrong operand in the address logic shows as a wrong pc_next. The random mix sends every opcode class, function codes that do not exist and opcodes that do not exist. Each instruction is also applied twice with the zero flag flipped. This exposes any dependence on the flag outside the branch case. Directed cases cover the address wrap, a negative branch offset and a jump from a PC with high upper bits.

// File: rtl/scu_pkg.sv
// Package: shared encodings and decoded-control bundle for the control unit.
// Assumes a 32-bit fixed-format instruction with op in [31:26] and func in [5:0].
package scu_pkg;

    localparam int OP_W     = 6;
    localparam int FUNC_W   = 6;
    localparam int ALU_OP_W = 3;
    localparam int IMM_W    = 16;
    localparam int JIDX_W   = 26;

    typedef enum logic [OP_W-1:0] {
        OPC_RTYPE = 6'b000000,
        OPC_JUMP  = 6'b000010,
        OPC_BEQ   = 6'b000100,
        OPC_LOAD  = 6'b100011,
        OPC_STORE = 6'b101011
    } opcode_e;

    typedef enum logic [FUNC_W-1:0] {
        FN_ADD = 6'b100000,
        FN_SUB = 6'b100010,
        FN_AND = 6'b100100,
        FN_OR  = 6'b100101,
        FN_SLT = 6'b101010
    } funct_e;

    typedef enum logic [ALU_OP_W-1:0] {
        ALU_AND = 3'b000,
        ALU_OR  = 3'b001,
        ALU_ADD = 3'b010,
        ALU_SUB = 3'b110,
        ALU_SLT = 3'b111
    } alu_op_e;

    // Source of the ALU operation chosen by the opcode decoder.
    typedef enum logic [1:0] {
        ALUSEL_ADD  = 2'd0,
        ALUSEL_SUB  = 2'd1,
        ALUSEL_FUNC = 2'd2
    } alu_sel_e;

    typedef struct packed {
        logic     reg_dst;
        logic     alu_src;
        logic     mem_to_reg;
        logic     reg_write;
        logic     mem_read;
        logic     mem_write;
        logic     is_branch;
        logic     is_jump;
        alu_sel_e alu_sel;
    } main_ctrl_t;

endpackage

// File: rtl/scu_main_dec.sv
// Module: opcode decoder. Maps the 6-bit op field to the datapath controls
// and to the source of the ALU operation.
// Assumes: unknown opcodes give all-zero controls with op_known low.
module scu_main_dec
    import scu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output main_ctrl_t      ctrl,
    output logic            op_known
);

    // Opcode lookup with a safe default for every field.
    always_comb begin
        ctrl         = '0;
        ctrl.alu_sel = ALUSEL_ADD;
        op_known     = 1'b1;
        case (op)
            OPC_RTYPE: begin
                ctrl.reg_dst   = 1'b1;
                ctrl.reg_write = 1'b1;
                ctrl.alu_sel   = ALUSEL_FUNC;
            end
            OPC_LOAD: begin
                ctrl.alu_src    = 1'b1;
                ctrl.mem_to_reg = 1'b1;
                ctrl.reg_write  = 1'b1;
                ctrl.mem_read   = 1'b1;
            end
            OPC_STORE: begin
                ctrl.alu_src   = 1'b1;
                ctrl.mem_write = 1'b1;
            end
            OPC_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_sel   = ALUSEL_SUB;
            end
            OPC_JUMP: begin
                ctrl.is_jump = 1'b1;
            end
            default: begin
                op_known = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/scu_alu_dec.sv
// Module: ALU operation decoder. Resolves the 3-bit ALU code from the opcode
// decoder's selection and, for register-format instructions, the func field.
// Assumes: an unknown func yields the add code with func_known low.
module scu_alu_dec
    import scu_pkg::*;
(
    input  alu_sel_e            alu_sel,
    input  logic [FUNC_W-1:0]   func,
    output logic [ALU_OP_W-1:0] alu_op,
    output logic                func_known
);

    // Pick a fixed code or look the func field up.
    always_comb begin
        alu_op     = ALU_ADD;
        func_known = 1'b1;
        case (alu_sel)
            ALUSEL_SUB: alu_op = ALU_SUB;
            ALUSEL_FUNC: begin
                case (func)
                    FN_ADD:  alu_op = ALU_ADD;
                    FN_SUB:  alu_op = ALU_SUB;
                    FN_AND:  alu_op = ALU_AND;
                    FN_OR:   alu_op = ALU_OR;
                    FN_SLT:  alu_op = ALU_SLT;
                    default: begin
                        alu_op     = ALU_ADD;
                        func_known = 1'b0;
                    end
                endcase
            end
            default: alu_op = ALU_ADD;
        endcase
    end

endmodule

// File: rtl/scu_next_pc.sv
// Module: next-PC generator. Forms the sequential, branch and jump addresses
// and selects one with jump first, taken branch second, sequential last.
// Assumes: XLEN >= 32 so the upper PC slice above the jump field is non-empty.
module scu_next_pc
    import scu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]   pc,
    input  logic [IMM_W-1:0]  imm,
    input  logic [JIDX_W-1:0] jidx,
    input  logic              take_branch,
    input  logic              take_jump,
    output logic [XLEN-1:0]   pc_next
);

    localparam int              UPPER_W = XLEN - JIDX_W - 2;
    localparam int              SEXT_W  = XLEN - IMM_W - 2;
    localparam logic [XLEN-1:0] STEP    = XLEN'(4);

    logic [XLEN-1:0] seq_addr;
    logic [XLEN-1:0] br_offset;
    logic [XLEN-1:0] br_addr;
    logic [XLEN-1:0] jmp_addr;

    // Candidate addresses.
    always_comb begin
        seq_addr  = pc + STEP;
        br_offset = {{SEXT_W{imm[IMM_W-1]}}, imm, 2'b00};
        br_addr   = seq_addr + br_offset;
        jmp_addr  = {pc[XLEN-1 -: UPPER_W], jidx, 2'b00};
    end

    // Priority selection of the next address.
    always_comb begin
        if (take_jump) begin
            pc_next = jmp_addr;
        end else if (take_branch) begin
            pc_next = br_addr;
        end else begin
            pc_next = seq_addr;
        end
    end

endmodule

// File: rtl/scu_ctrl.sv
// Module: top of the merged control and next-PC unit. Purely combinational.
// Assumes: the caller registers pc_next into its PC; unknown encodings must
// leave architectural state untouched, so all controls are gated by validity.
module scu_ctrl
    import scu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [31:0]         instr,
    input  logic                alu_zero,
    input  logic [XLEN-1:0]     pc,
    output logic                reg_dst,
    output logic                alu_src,
    output logic                mem_to_reg,
    output logic                reg_write,
    output logic                mem_read,
    output logic                mem_write,
    output logic                branch_taken,
    output logic                jump,
    output logic [ALU_OP_W-1:0] alu_op,
    output logic [XLEN-1:0]     pc_next
);

    localparam int OP_LSB = 32 - OP_W;

    main_ctrl_t          dec;
    logic                op_known;
    logic                func_known;
    logic [ALU_OP_W-1:0] alu_op_raw;
    logic                instr_ok;

    scu_main_dec u_main_dec (
        .op       (instr[31:OP_LSB]),
        .ctrl     (dec),
        .op_known (op_known)
    );

    scu_alu_dec u_alu_dec (
        .alu_sel    (dec.alu_sel),
        .func       (instr[FUNC_W-1:0]),
        .alu_op     (alu_op_raw),
        .func_known (func_known)
    );

    // An encoding is usable when the opcode is known and, if it needs one, the func.
    always_comb begin
        instr_ok = op_known && ((dec.alu_sel != ALUSEL_FUNC) || func_known);
    end

    // Gate every control with validity; resolve branch with the zero flag.
    always_comb begin
        reg_dst      = instr_ok & dec.reg_dst;
        alu_src      = instr_ok & dec.alu_src;
        mem_to_reg   = instr_ok & dec.mem_to_reg;
        reg_write    = instr_ok & dec.reg_write;
        mem_read     = instr_ok & dec.mem_read;
        mem_write    = instr_ok & dec.mem_write;
        branch_taken = instr_ok & dec.is_branch & alu_zero;
        jump         = instr_ok & dec.is_jump;
        alu_op       = alu_op_raw;
    end

    scu_next_pc #(.XLEN(XLEN)) u_next_pc (
        .pc          (pc),
        .imm         (instr[IMM_W-1:0]),
        .jidx        (instr[JIDX_W-1:0]),
        .take_branch (branch_taken),
        .take_jump   (jump),
        .pc_next     (pc_next)
    );

endmodule

// File: rtl/scu_ctrl_chk.sv
// Module: checker for scu_ctrl. Relates control outputs to each other and
// to the inputs; bound into every scu_ctrl instance below.
// Assumes: inputs are driven to known values; checks skip unknown inputs.
module scu_ctrl_chk #(
    parameter int XLEN = 32
) (
    input logic [31:0]     instr,
    input logic            alu_zero,
    input logic [XLEN-1:0] pc,
    input logic            reg_dst,
    input logic            alu_src,
    input logic            mem_to_reg,
    input logic            reg_write,
    input logic            mem_read,
    input logic            mem_write,
    input logic            branch_taken,
    input logic            jump,
    input logic [2:0]      alu_op,
    input logic [XLEN-1:0] pc_next
);

    localparam logic [XLEN-1:0] STEP = XLEN'(4);

    // Cross-output consistency checks once the inputs are known.
    always_comb begin
        if (!$isunknown({instr, alu_zero, pc})) begin
            AST_LOAD_BUNDLE: assert (!mem_read || (mem_to_reg && alu_src && reg_write && !mem_write)); // R2
            AST_STORE_NO_REG: assert (!mem_write || (!reg_write && !mem_read && alu_src)); // R3
            AST_TAKEN_NEEDS_ZERO: assert (!branch_taken || (alu_zero && alu_op == 3'b110)); // R4
            AST_JUMP_TARGET: assert (!jump || pc_next == {pc[XLEN-1 -: XLEN-28], instr[25:0], 2'b00}); // R6
            AST_JUMP_NOT_BRANCH: assert (!(jump && branch_taken)); // R6
            AST_SEQ_PC: assert (jump || branch_taken || pc_next == pc + STEP); // R7
            AST_REGDST_RTYPE: assert (!reg_dst || (reg_write && !alu_src)); // R1
        end
    end

endmodule

bind scu_ctrl scu_ctrl_chk #(.XLEN(XLEN)) u_scu_ctrl_chk (
    .instr        (instr),
    .alu_zero     (alu_zero),
    .pc           (pc),
    .reg_dst      (reg_dst),
    .alu_src      (alu_src),
    .mem_to_reg   (mem_to_reg),
    .reg_write    (reg_write),
    .mem_read     (mem_read),
    .mem_write    (mem_write),
    .branch_taken (branch_taken),
    .jump         (jump),
    .alu_op       (alu_op),
    .pc_next      (pc_next)
);

// File: tb/scu_ctrl_test.sv
`timescale 1ns/1ps
// Bench: directed corners plus seeded random instructions, each compared
// against an independent reference model of the requirements.
module scu_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] instr = '0;
    logic        alu_zero = 1'b0;
    logic [31:0] pc = '0;
    logic        reg_dst, alu_src, mem_to_reg, reg_write;
    logic        mem_read, mem_write, branch_taken, jump;
    logic [2:0]  alu_op;
    logic [31:0] pc_next;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    scu_ctrl uut (
        .instr        (instr),
        .alu_zero     (alu_zero),
        .pc           (pc),
        .reg_dst      (reg_dst),
        .alu_src      (alu_src),
        .mem_to_reg   (mem_to_reg),
        .reg_write    (reg_write),
        .mem_read     (mem_read),
        .mem_write    (mem_write),
        .branch_taken (branch_taken),
        .jump         (jump),
        .alu_op       (alu_op),
        .pc_next      (pc_next)
    );

    // Reference model: {reg_dst,alu_src,mem_to_reg,reg_write,mem_read,mem_write,taken,jump,alu_op,pc_next}
    function automatic logic [42:0] model(input logic [31:0] i, input logic z, input logic [31:0] p);
        logic [7:0]  c;
        logic [2:0]  a;
        logic [31:0] np;
        c  = 8'b0;
        a  = 3'b010;
        np = p + 32'd4;
        case (i[31:26])
            6'b000000: begin
                c = 8'b1001_0000;
                case (i[5:0])
                    6'b100000: a = 3'b010;
                    6'b100010: a = 3'b110;
                    6'b100100: a = 3'b000;
                    6'b100101: a = 3'b001;
                    6'b101010: a = 3'b111;
                    default:   c = 8'b0;
                endcase
            end
            6'b100011: c = 8'b0111_1000;
            6'b101011: c = 8'b0100_0100;
            6'b000100: begin
                a = 3'b110;
                if (z) begin
                    c  = 8'b0000_0010;
                    np = p + 32'd4 + {{14{i[15]}}, i[15:0], 2'b00};
                end
            end
            6'b000010: begin
                c  = 8'b0000_0001;
                np = {p[31:28], i[25:0], 2'b00};
            end
            default: ;
        endcase
        return {c, a, np};
    endfunction

    // Requirement tag for an instruction class.
    function automatic string req_of(input logic [31:0] i, input logic z);
        case (i[31:26])
            6'b000000: begin
                case (i[5:0])
                    6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010: return z ? "R9" : "R1";
                    default: return "R8";
                endcase
            end
            6'b100011: return z ? "R9" : "R2";
            6'b101011: return z ? "R9" : "R3";
            6'b000100: return z ? "R5" : "R4";
            6'b000010: return "R6";
            default:   return "R8";
        endcase
    endfunction

    task automatic check(input string req, input logic [42:0] act, input logic [42:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%h pc=%h zero=%0b actual=%h expected=%h", req, instr, pc, alu_zero, act, exp);
        end
    endtask

    // Drive after a rising edge, compare at the following falling edge.
    task automatic apply(input logic [31:0] i, input logic z, input logic [31:0] p, input string req);
        @(posedge clk);
        instr    <= i;
        alu_zero <= z;
        pc       <= p;
        @(negedge clk);
        check(req, {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write,
                    branch_taken, jump, alu_op, pc_next}, model(i, z, p));
    endtask

    function automatic logic [31:0] rnd_instr();
        logic [31:0] r;
        logic [5:0]  fl [5];
        fl[0] = 6'b100000; fl[1] = 6'b100010; fl[2] = 6'b100100;
        fl[3] = 6'b100101; fl[4] = 6'b101010;
        r = $urandom;
        case ($urandom % 10)
            0, 1, 2: r = {6'b000000, r[25:6], fl[$urandom % 5]};
            3:       r[31:26] = 6'b100011;
            4:       r[31:26] = 6'b101011;
            5:       r[31:26] = 6'b000100;
            6:       r[31:26] = 6'b000010;
            7:       r[31:26] = 6'b000000;
            default: ;
        endcase
        return r;
    endfunction

    initial begin
        #(4 * 150000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7713));
        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
        @(negedge clk);
        // Idle word (op 0, func 0) after reset is an unknown encoding: R8
        check("R8", {reg_dst, alu_src, mem_to_reg, reg_write, mem_read, mem_write,
                     branch_taken, jump, alu_op, pc_next}, model(32'h0, 1'b0, 32'h0));
        // R1: every func code
        apply(32'h0109_4020, 1'b0, 32'h0040_0000, "R1");
        apply(32'h0109_4022, 1'b0, 32'h0040_0004, "R1");
        apply(32'h0109_4024, 1'b0, 32'h0040_0008, "R1");
        apply(32'h0109_4025, 1'b0, 32'h0040_000C, "R1");
        apply(32'h0109_402A, 1'b0, 32'h0040_0010, "R1");
        apply(32'h8FA8_FFFC, 1'b0, 32'h0040_0014, "R2");
        apply(32'hAFA4_0010, 1'b0, 32'h0040_0018, "R3");
        apply(32'h1020_0003, 1'b0, 32'h0040_001C, "R4");
        apply(32'h1020_0003, 1'b1, 32'h0040_001C, "R5");
        apply(32'h1020_8000, 1'b1, 32'h0000_1000, "R5");
        apply(32'h0BFF_FFFF, 1'b1, 32'hA000_0000, "R6");
        apply(32'h0800_0000, 1'b0, 32'h7FFF_FFF0, "R6");
        apply(32'h0109_4020, 1'b0, 32'hFFFF_FFFC, "R7");
        apply(32'h0109_4021, 1'b1, 32'h0000_0100, "R8");
        apply(32'hFC00_0000, 1'b1, 32'h0000_0200, "R8");
        apply(32'h8FA8_0004, 1'b1, 32'h0000_0300, "R9");
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ri;
            logic [31:0] rp;
            ri = rnd_instr();
            rp = $urandom;
            apply(ri, 1'b0, rp, req_of(ri, 1'b0));
            apply(ri, 1'b1, rp, req_of(ri, 1'b1));
        end
        finished = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule